// File: doc/BRIEF.md
# Single-Lane Structure Micro-Op Expander

This block sits in an instruction decoder. It takes one SIMD load or store that moves a single structure. That structure is one element per vector register, and the element goes either into one chosen lane or, for loads, is copied to every lane. The block expands the instruction into an ordered stream of micro-op records.

Each record names its kind and carries the fields that kind needs:
- memory transfer width and element size for the memory access;
- the register-pair slot, slot stride and temporary-slot variant for the pack or unpack step;
- the immediate for base-register writeback.

The block accepts one request at a time through a valid/ready pair. It then presents the records one by one on a second valid/ready pair. An illegal request produces a one-cycle error pulse and no records. The block does not move any data.

Top module: `lane_struct_expander`

## Requirements
- R1: `req_ready` is high whenever no stream is in progress. A request accepted on a clock edge presents its first record in the following cycle. While a stream is in progress, `req_ready` is low and `req_valid` has no effect.
- R2: The element size is 1 << `req_size` bytes. The transfer size is the element size times the element count. The single memory record (kind 0 = load, kind 1 = store) carries the transfer size in `uop_bytes`, which is one of 1, 2, 3, 4, 6, 8, 12 or 16. On records of other kinds `uop_bytes` is 0.
- R3: A stream holds exactly 1 + W + P records. W is 1 when writeback applies. P is the register count when the element count is 1, and 1 otherwise.
- R4: Writeback is skipped when `req_ofs` = 15. When `req_ofs` = 13 it is an immediate add (kind 3) with `uop_imm` equal to the transfer size. Any other index gives a register add (kind 2). `uop_imm` is 0 on every record except kind 3.
- R5: Loads are emitted as memory, then writeback, then unpack. Stores are emitted as pack (kind 6), then memory, then writeback.
- R6: A load with `req_all` clear uses lane-insert unpack (kind 4), which carries `uop_lane`. A load with `req_all` set uses replicate unpack (kind 5), which carries `uop_lane` = 0. A store with `req_all` set is illegal.
- R7: On pack and unpack records:
  - `uop_tmp_slots` is 4 for 4-byte elements with an element count of 3 or 4, and 2 otherwise;
  - `uop_reg_slots` is twice the element count;
  - `uop_vstep` is twice the stride.
  These three fields are 0 on other records.
- R8: With element count 1, the register count must be 1, or 2 when `req_all` is set. The k-th pack or unpack record targets slot ((vd + k) mod 2^VREG_W) * 2.
- R9: The following requests are illegal:
  - an element count or register count outside 1..4;
  - element count 2 without register count 2;
  - element count 3 or 4 without an equal register count;
  - `req_size` = 3;
  - a lane that is not below 8 / element bytes, unless replication is selected.
  An illegal request raises `err` for one cycle after acceptance and emits nothing.
- R10: Every record except the final one has `uop_delay` set and `uop_last` clear. The final record has `uop_last` set and `uop_delay` clear.
- R11: While `uop_valid` is high and `uop_ready` is low, the presented record is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_all | input | 1 | Replicate to all lanes |
| req_elems | input | 3 | Element count |
| req_regs | input | 3 | Register count |
| req_size | input | 2 | Element size code |
| req_lane | input | 3 | Lane index |
| req_align | input | ALIGN_W | Alignment code, passed through |
| req_base | input | GREG_W | Base address register |
| req_ofs | input | GREG_W | Offset register index |
| req_vd | input | VREG_W | First vector register |
| req_stride | input | 2 | Register stride |
| err | output | 1 | Illegal request pulse |
| uop_valid | output | 1 | Record present |
| uop_ready | input | 1 | Record consumed |
| uop_kind | output | 3 | Record kind |
| uop_bytes | output | 5 | Memory transfer width |
| uop_esize | output | 2 | Element size code |
| uop_lane | output | 3 | Lane for lane-insert and pack |
| uop_align | output | ALIGN_W | Alignment code |
| uop_base | output | GREG_W | Base register |
| uop_ofs | output | GREG_W | Offset register |
| uop_imm | output | 5 | Writeback immediate |
| uop_vslot | output | VREG_W+1 | Register-pair slot |
| uop_vstep | output | 3 | Slot stride |
| uop_tmp_slots | output | 3 | Temporary slot count of the variant |
| uop_reg_slots | output | 4 | Destination/source slot count |
| uop_delay | output | 1 | Delayed commit |
| uop_last | output | 1 | Final record |

## Verification
The bench builds the block with its default parameters: GREG_W=4, VREG_W=5 and ALIGN_W=2. With these values, index 13 and index 15 are both reachable on the offset port, so all three writeback modes get exercised. A 5-bit vd lets random requests land at vd = 31. There, the second replicate record of a two-register load wraps the slot sum, and that wrap is checked against the modular result.

// File: rtl/lane_struct_expander.sv
module lane_struct_expander #(
  parameter int GREG_W     = 4,
  parameter int VREG_W     = 5,
  parameter int ALIGN_W    = 2,
  parameter int NO_WB_REG  = 15,
  parameter int IMM_WB_REG = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic               req_all,
  input  logic [2:0]         req_elems,
  input  logic [2:0]         req_regs,
  input  logic [1:0]         req_size,
  input  logic [2:0]         req_lane,
  input  logic [ALIGN_W-1:0] req_align,
  input  logic [GREG_W-1:0]  req_base,
  input  logic [GREG_W-1:0]  req_ofs,
  input  logic [VREG_W-1:0]  req_vd,
  input  logic [1:0]         req_stride,
  output logic               err,
  output logic               uop_valid,
  input  logic               uop_ready,
  output logic [2:0]         uop_kind,
  output logic [4:0]         uop_bytes,
  output logic [1:0]         uop_esize,
  output logic [2:0]         uop_lane,
  output logic [ALIGN_W-1:0] uop_align,
  output logic [GREG_W-1:0]  uop_base,
  output logic [GREG_W-1:0]  uop_ofs,
  output logic [4:0]         uop_imm,
  output logic [VREG_W:0]    uop_vslot,
  output logic [2:0]         uop_vstep,
  output logic [2:0]         uop_tmp_slots,
  output logic [3:0]         uop_reg_slots,
  output logic               uop_delay,
  output logic               uop_last
);
  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_ADDR = 3'd2, K_ADDI = 3'd3,
                         K_UNPK = 3'd4, K_UNPK_ALL = 3'd5, K_PACK = 3'd6;
  localparam logic [GREG_W-1:0] NO_WB  = GREG_W'(NO_WB_REG);
  localparam logic [GREG_W-1:0] IMM_WB = GREG_W'(IMM_WB_REG);

  logic               busy, st_q, all_q;
  logic [2:0]         elems_q, regs_q, lane_q, idx_q;
  logic [1:0]         size_q, stride_q;
  logic [ALIGN_W-1:0] align_q;
  logic [GREG_W-1:0]  base_q, ofs_q;
  logic [VREG_W-1:0]  vd_q;

  logic shape_ok, lane_ok, legal;
  always_comb begin
    case (req_elems)
      3'd1:    shape_ok = (req_regs == 3'd1) || (req_all && req_regs == 3'd2);
      3'd2:    shape_ok = (req_regs == 3'd2);
      3'd3:    shape_ok = (req_regs == 3'd3);
      3'd4:    shape_ok = (req_regs == 3'd4);
      default: shape_ok = 1'b0;
    endcase
  end
  assign lane_ok = req_all || ({1'b0, req_lane} < (4'd8 >> req_size));
  assign legal   = shape_ok && lane_ok && (req_size != 2'd3) && !(req_store && req_all);

  logic [4:0] xfer;
  logic       wb;
  logic [2:0] n_pk, total, k;
  logic       last;
  logic [2:0] kind;
  assign xfer  = 5'({2'b00, elems_q} << size_q);
  assign wb    = (ofs_q != NO_WB);
  assign n_pk  = (elems_q == 3'd1) ? regs_q : 3'd1;
  assign total = 3'd1 + {2'b00, wb} + n_pk;
  assign last  = (idx_q == total - 3'd1);

  always_comb begin
    k = 3'd0;
    if (!st_q) begin
      if (idx_q == 3'd0)             kind = K_LD;
      else if (wb && idx_q == 3'd1)  kind = (ofs_q == IMM_WB) ? K_ADDI : K_ADDR;
      else begin
        kind = all_q ? K_UNPK_ALL : K_UNPK;
        k    = idx_q - 3'd1 - {2'b00, wb};
      end
    end else begin
      if (idx_q < n_pk) begin
        kind = K_PACK;
        k    = idx_q;
      end
      else if (idx_q == n_pk) kind = K_ST;
      else                    kind = (ofs_q == IMM_WB) ? K_ADDI : K_ADDR;
    end
  end

  logic is_mem, is_pk;
  logic [VREG_W-1:0] vsum;
  assign is_mem = (kind == K_LD) || (kind == K_ST);
  assign is_pk  = (kind == K_UNPK) || (kind == K_UNPK_ALL) || (kind == K_PACK);
  assign vsum   = vd_q + VREG_W'(k);

  assign req_ready     = !busy;
  assign uop_valid     = busy;
  assign uop_kind      = kind;
  assign uop_bytes     = is_mem ? xfer : 5'd0;
  assign uop_imm       = (kind == K_ADDI) ? xfer : 5'd0;
  assign uop_esize     = size_q;
  assign uop_align     = align_q;
  assign uop_base      = base_q;
  assign uop_ofs       = ofs_q;
  assign uop_lane      = (kind == K_UNPK || kind == K_PACK) ? lane_q : 3'd0;
  assign uop_vslot     = is_pk ? {vsum, 1'b0} : '0;
  assign uop_vstep     = is_pk ? {stride_q, 1'b0} : 3'd0;
  assign uop_tmp_slots = !is_pk ? 3'd0 : (size_q == 2'd2 && elems_q >= 3'd3) ? 3'd4 : 3'd2;
  assign uop_reg_slots = is_pk ? {elems_q, 1'b0} : 4'd0;
  assign uop_last      = last;
  assign uop_delay     = !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; idx_q <= '0;
      st_q <= 1'b0; all_q <= 1'b0; elems_q <= '0; regs_q <= '0; lane_q <= '0;
      size_q <= '0; stride_q <= '0; align_q <= '0; base_q <= '0; ofs_q <= '0; vd_q <= '0;
    end else begin
      err <= 1'b0;
      if (req_valid && !busy) begin
        if (legal) begin
          busy <= 1'b1; idx_q <= '0;
          st_q <= req_store; all_q <= req_all; elems_q <= req_elems; regs_q <= req_regs;
          lane_q <= req_lane; size_q <= req_size; stride_q <= req_stride;
          align_q <= req_align; base_q <= req_base; ofs_q <= req_ofs; vd_q <= req_vd;
        end else begin
          err <= 1'b1;
        end
      end else if (busy && uop_ready) begin
        if (last) busy <= 1'b0;
        else      idx_q <= idx_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/lane_struct_expander_chk.sv
module lane_struct_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err,
  input logic       uop_valid,
  input logic       uop_ready,
  input logic [2:0] uop_kind,
  input logic [4:0] uop_bytes,
  input logic [4:0] uop_imm,
  input logic       uop_last
);
  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !uop_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_bytes) && $stable(uop_imm));

  p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && uop_last |=> !uop_valid);

  p_more_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready && !uop_last |=> uop_valid);

  p_first_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uop_valid) |-> (uop_kind == 3'd0 || uop_kind == 3'd6));

  p_mem_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && (uop_kind == 3'd0 || uop_kind == 3'd1) |-> (uop_bytes inside {5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16}));

  p_imm_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind == 3'd3 |-> (uop_imm inside {5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16}));
endmodule

bind lane_struct_expander lane_struct_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err(err), .uop_valid(uop_valid), .uop_ready(uop_ready),
  .uop_kind(uop_kind), .uop_bytes(uop_bytes), .uop_imm(uop_imm), .uop_last(uop_last)
);

// File: tb/lane_struct_expander_bench.sv
module lane_struct_expander_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_store, req_all, err, uop_valid, uop_ready;
  logic [2:0] req_elems, req_regs, req_lane;
  logic [1:0] req_size, req_align, req_stride;
  logic [3:0] req_base, req_ofs;
  logic [4:0] req_vd;
  logic [2:0] uop_kind, uop_lane, uop_vstep, uop_tmp_slots;
  logic [4:0] uop_bytes, uop_imm;
  logic [1:0] uop_esize, uop_align;
  logic [3:0] uop_base, uop_ofs, uop_reg_slots;
  logic [5:0] uop_vslot;
  logic uop_delay, uop_last;

  lane_struct_expander u_lane_struct_expander (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bit cur_st, cur_all;
  int cur_e, cur_r, cur_sz, cur_ln, cur_al, cur_b, cur_o, cur_vd, cur_sd;

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_legal();
    bit shape;
    case (cur_e)
      1: shape = (cur_r == 1) || (cur_all && cur_r == 2);
      2: shape = (cur_r == 2);
      3: shape = (cur_r == 3);
      4: shape = (cur_r == 4);
      default: shape = 0;
    endcase
    return shape && cur_sz <= 2 && !(cur_st && cur_all) && (cur_all || cur_ln < (8 >> cur_sz));
  endfunction

  function automatic int exp_count();
    return 1 + (cur_o != 15 ? 1 : 0) + (cur_e == 1 ? cur_r : 1);
  endfunction

  task automatic check_uop(int idx);
    int kinds[4], ks[4];
    int n = 0, xf, np, kd;
    bit wb;
    xf = (1 << cur_sz) * cur_e;
    wb = (cur_o != 15);
    np = (cur_e == 1) ? cur_r : 1;
    for (int i = 0; i < 4; i++) begin kinds[i] = 0; ks[i] = 0; end
    if (!cur_st) begin
      kinds[n] = 0; n++;
      if (wb) begin kinds[n] = (cur_o == 13) ? 3 : 2; n++; end
      for (int k = 0; k < np; k++) begin kinds[n] = cur_all ? 5 : 4; ks[n] = k; n++; end
    end else begin
      for (int k = 0; k < np; k++) begin kinds[n] = 6; ks[n] = k; n++; end
      kinds[n] = 1; n++;
      if (wb) begin kinds[n] = (cur_o == 13) ? 3 : 2; n++; end
    end
    kd = kinds[idx];
    chk("R1 valid", uop_valid, 1);
    chk("R5 kind", uop_kind, kd);
    chk("R2 bytes", uop_bytes, (kd <= 1) ? xf : 0);
    chk("R2 esize", uop_esize, cur_sz);
    chk("R4 imm", uop_imm, (kd == 3) ? xf : 0);
    chk("R4 base/ofs", {uop_base, uop_ofs, uop_align}, {4'(cur_b), 4'(cur_o), 2'(cur_al)});
    chk("R6 lane", uop_lane, (kd == 4 || kd == 6) ? cur_ln : 0);
    chk("R8 vslot", uop_vslot, (kd >= 4) ? ((cur_vd + ks[idx]) % 32) * 2 : 0);
    chk("R7 vstep", uop_vstep, (kd >= 4) ? cur_sd * 2 : 0);
    chk("R7 tmp_slots", uop_tmp_slots, (kd >= 4) ? ((cur_sz == 2 && cur_e >= 3) ? 4 : 2) : 0);
    chk("R7 reg_slots", uop_reg_slots, (kd >= 4) ? cur_e * 2 : 0);
    chk("R10 last", {uop_last, uop_delay}, (idx == n - 1) ? 2'b10 : 2'b01);
  endtask

  task automatic run_req(bit st, bit al, int e, int r, int sz, int ln, int o, int vd, bit spam);
    int n, stalls;
    cur_st = st; cur_all = al; cur_e = e; cur_r = r; cur_sz = sz; cur_ln = ln; cur_o = o;
    cur_vd = vd; cur_al = $urandom_range(0, 3); cur_b = $urandom_range(0, 15); cur_sd = $urandom_range(1, 2);
    @(negedge clk);
    req_store = st; req_all = al; req_elems = 3'(e); req_regs = 3'(r); req_size = 2'(sz);
    req_lane = 3'(ln); req_ofs = 4'(o); req_vd = 5'(vd); req_align = 2'(cur_al);
    req_base = 4'(cur_b); req_stride = 2'(cur_sd); req_valid = 1; uop_ready = 0;
    chk("R1 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (!exp_legal()) begin
      chk("R9 err", err, 1);
      chk("R9 nothing emitted", uop_valid, 0);
      @(negedge clk);
      chk("R9 err one cycle", {err, uop_valid}, 0);
      return;
    end
    chk("R9 no err", err, 0);
    if (spam) begin
      req_valid = 1; req_store = !st; req_elems = 3'd1; req_regs = 3'd1; req_size = 2'd0;
      req_lane = 3'd0; req_all = 0; req_ofs = 4'd13;
      chk("R1 busy not ready", req_ready, 0);
      @(negedge clk);
      req_valid = 0;
    end
    n = exp_count();
    for (int i = 0; i < n; i++) begin
      stalls = $urandom_range(0, 2);
      for (int s = 0; s < stalls; s++) begin
        uop_ready = 0;
        check_uop(i);
        @(negedge clk);
        chk("R11 held", uop_valid, 1);
      end
      uop_ready = 1;
      check_uop(i);
      @(negedge clk);
      uop_ready = 0;
    end
    chk("R3 stream length", {uop_valid, req_ready}, 2'b01);
    chk("R9 no err after", err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; req_valid = 0; uop_ready = 0; req_store = 0; req_all = 0; req_elems = 0;
    req_regs = 0; req_size = 0; req_lane = 0; req_align = 0; req_base = 0; req_ofs = 0;
    req_vd = 0; req_stride = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {uop_valid, err, req_ready}, 3'b001);
    rst_n = 1;
    // directed corners
    run_req(0, 1, 1, 2, 1, 0, 15, 31, 0);  // R8 replicate two registers, slot wraps
    run_req(1, 0, 3, 3, 2, 1, 13, 4, 0);   // R7 four-slot store, 12-byte transfer
    run_req(0, 0, 4, 4, 0, 7, 13, 2, 1);   // R4 immediate, R1 request ignored while busy
    run_req(0, 0, 1, 1, 2, 1, 7, 9, 0);    // R4 register writeback
    run_req(1, 1, 1, 1, 0, 0, 15, 0, 0);   // R6 store with replicate is illegal
    run_req(0, 0, 1, 1, 2, 2, 15, 0, 0);   // R9 lane out of range
    run_req(0, 0, 1, 1, 3, 0, 15, 0, 0);   // R9 size code 3
    run_req(0, 0, 2, 4, 0, 0, 15, 0, 0);   // R9 element count 2 needs 2 registers
    run_req(0, 0, 1, 2, 0, 0, 15, 0, 0);   // R8 two registers without replicate
    run_req(0, 1, 3, 3, 1, 7, 15, 6, 0);   // R6 lane ignored with replicate
    run_req(1, 0, 2, 2, 2, 1, 5, 3, 0);    // R2 8-byte store
    for (int t = 0; t < 300; t++) begin
      bit st, al;
      int e, r, sz, ln, o;
      st = 1'($urandom_range(0, 1));
      al = st ? ($urandom_range(0, 19) == 0) : 1'($urandom_range(0, 1));
      e  = $urandom_range(1, 4);
      r  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 4) : e;
      if (e == 1 && al && $urandom_range(0, 1) == 1) r = 2;
      sz = ($urandom_range(0, 9) == 0) ? 3 : $urandom_range(0, 2);
      ln = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 7) : $urandom_range(0, (8 >> (sz == 3 ? 2 : sz)) - 1);
      case ($urandom_range(0, 2))
        0: o = 15;
        1: o = 13;
        default: o = $urandom_range(0, 15);
      endcase
      run_req(st, al, e, r, sz, ln, o, $urandom_range(0, 31), $urandom_range(0, 7) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule